// File: doc/BRIEF.md
# NAND Flash Bus Controller

This block lets a processor drive an 8-bit NAND flash part through a small register window on a 32-bit request/ready bus. Software selects the chip and turns the controller on through a configuration register. It then issues command and address bytes with one register write each, and moves page data one byte at a time through a data register. The controller produces the matching flash pin sequence for every such access: latch-enable levels, the byte on the shared I/O lines, and a write or read strobe. The register bus is stalled until the flash cycle has finished.

Every byte that passes through the data register, whether written or read, is folded into a Hamming-style error-code accumulator. The accumulator tracks line parity by byte position and column parity by bit position over a block of bytes. Software reads the packed 24-bit code one byte at a time, compares it with the code kept in the spare area, and clears the accumulator with a single action bit in the configuration register. The ready/busy line of the flash can be read in a status register. The chip-enable level and the write-protect level go straight to the flash pins.

Top module: `nand_bus_ctrl`

## Requirements
- R1: Valid offsets are config 0x00, command 0x04, address 0x08, data 0x0C (read and write), status 0x10 (read only) and ECC 0x14, 0x15, 0x16 (read only). Any other access completes with bus_err high together with bus_ready, returns zero data and changes no state.
- R2: A config write keeps bit 15 and bits 11:0. Bits 14:12 and 31:16 are discarded, so bit 12 always reads back as zero. The config register resets to zero.
- R3: While config bit 15 (enable) is clear, command, address and data accesses produce no strobe on the flash pins and do not touch the ECC. A data read then returns zero. The command and address registers still store their byte.
- R4: A config write with bit 12 set clears the ECC accumulator, including its byte position, in the same access.
- R5: nf_ce_lvl follows config bit 11 and nf_wp_n follows wp_n_in.
- R6: A command write stores bits 7:0 and, when enabled, drives that byte on nf_io_out with nf_cle high and nf_ale low for the whole write strobe. CLE drops after the strobe.
- R7: An address write does the same with nf_ale high and nf_cle low.
- R8: An enabled data write sends bits 7:0 with both latch enables low. An enabled data read pulses nf_re_n, releases the I/O lines and returns the byte sampled from nf_io_in in bits 7:0. Both bytes enter the ECC accumulator.
- R9: The ECC word is stored inverted. For k = 0..8, bit 2k is the inverse of odd line parity k and bit 2k+1 is the inverse of even line parity k. Bits 23:18 are the inverse of column parities 5..0. A cleared accumulator, or 256 bytes of 0xFF, reads as 0xFFFFFF.
- R10: ECC offset 0x14 returns word bits 7:0, 0x15 returns bits 15:8 and 0x16 returns bits 23:16, each in bits 7:0 of the read data.
- R11: Status bit 0 returns the level of nf_rb. All other status bits read zero.
- R12: Let p be the XOR of a byte. For byte index i and k in 0..7, p toggles odd parity k if bit k of i is 1, and even parity k otherwise. p also toggles even parity 8. Column parities are: 0 = d0^d2^d4^d6, 1 = d1^d3^d5^d7, 2 = d0^d1^d4^d5, 3 = d2^d3^d6^d7, 4 = d0^d1^d2^d3, 5 = d4^d5^d6^d7. The index wraps from 255 to 0.
- R13: Each flash strobe stays low for exactly STROBE_CLKS clocks. bus_ready is a single-cycle pulse that ends every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, held until bus_ready |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Access to an invalid offset, valid with bus_ready |
| nf_io_out | output | 8 | Byte driven to the flash I/O lines |
| nf_io_oe | output | 1 | Drive enable for the I/O lines |
| nf_io_in | input | 8 | Byte from the flash I/O lines |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_ce_lvl | output | 1 | Chip-enable pin level |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_wp_n | output | 1 | Write-protect pin level to the flash |
| wp_n_in | input | 1 | Write-protect level from the system |
| nf_rb | input | 1 | Flash ready/busy |

## Verification
The bench builds the block with its defaults: STROBE_CLKS = 2 and a 256-byte ECC block. At these values a single sweep can cover every byte index and every line-parity pair, and then run past the index wrap. A full 256-byte pass visits all byte values through a permutation. The erased-page case and a single-byte case pin down each ECC bit position by hand. Strobe widths are measured at the pins against the parameter.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

    localparam int BUS_AW = 5;

    typedef enum logic [1:0] {OP_CMD, OP_ADDR, OP_DWR, OP_DRD} flash_op_e;
    typedef enum logic [1:0] {BUS_IDLE, BUS_WAIT, BUS_RESP} bus_st_e;
    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

    localparam logic [BUS_AW-1:0] OFF_CFG  = 5'h00;
    localparam logic [BUS_AW-1:0] OFF_CMD  = 5'h04;
    localparam logic [BUS_AW-1:0] OFF_ADR  = 5'h08;
    localparam logic [BUS_AW-1:0] OFF_DAT  = 5'h0C;
    localparam logic [BUS_AW-1:0] OFF_STS  = 5'h10;
    localparam logic [BUS_AW-1:0] OFF_ECC0 = 5'h14;
    localparam logic [BUS_AW-1:0] OFF_ECC1 = 5'h15;
    localparam logic [BUS_AW-1:0] OFF_ECC2 = 5'h16;

    localparam logic [15:0] CFG_KEEP = 16'h8FFF;
    localparam int CFG_EN_BIT  = 15;
    localparam int CFG_CLR_BIT = 12;
    localparam int CFG_CE_BIT  = 11;

    // column parity groups of one data byte
    function automatic logic [5:0] col_par(input logic [7:0] b);
        logic [5:0] c;
        c[0] = b[0] ^ b[2] ^ b[4] ^ b[6];
        c[1] = b[1] ^ b[3] ^ b[5] ^ b[7];
        c[2] = b[0] ^ b[1] ^ b[4] ^ b[5];
        c[3] = b[2] ^ b[3] ^ b[6] ^ b[7];
        c[4] = ^b[3:0];
        c[5] = ^b[7:4];
        return c;
    endfunction

endpackage

// File: rtl/nbc_ecc_acc.sv
module nbc_ecc_acc #(
    parameter int BLOCK_BYTES = 256,
    localparam int IDX_W = $clog2(BLOCK_BYTES),
    localparam int PAIRS = IDX_W + 1,
    localparam int ECC_W = 2 * PAIRS + 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd,
    input  logic [7:0]       byte_in,
    output logic [ECC_W-1:0] ecc_word
);
    import nbc_pkg::*;

    typedef struct packed {
        logic [PAIRS-1:0] lp_even;
        logic [PAIRS-1:0] lp_odd;
        logic [5:0]       cp;
        logic [IDX_W-1:0] idx;
    } acc_t;

    acc_t acc_d, acc_q;
    logic par;

    always_comb begin
        acc_d = acc_q;
        par   = ^byte_in;
        if (clr) begin
            acc_d = '0;
        end else if (upd) begin
            for (int k = 0; k < IDX_W; k++) begin
                if (acc_q.idx[k]) acc_d.lp_odd[k]  = acc_q.lp_odd[k] ^ par;
                else              acc_d.lp_even[k] = acc_q.lp_even[k] ^ par;
            end
            acc_d.lp_even[IDX_W] = acc_q.lp_even[IDX_W] ^ par;
            acc_d.cp  = acc_q.cp ^ col_par(byte_in);
            acc_d.idx = acc_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    for (genvar k = 0; k < PAIRS; k++) begin : g_pack
        assign ecc_word[2*k]   = ~acc_q.lp_odd[k];
        assign ecc_word[2*k+1] = ~acc_q.lp_even[k];
    end
    assign ecc_word[ECC_W-1 -: 6] = ~acc_q.cp;

endmodule

// File: rtl/nbc_pin_seq.sv
module nbc_pin_seq #(
    parameter int STROBE_CLKS = 2,
    localparam int CNT_W = $clog2(STROBE_CLKS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  nbc_pkg::flash_op_e  start_op,
    input  logic [7:0]          start_byte,
    input  logic [7:0]          io_in,
    output logic [7:0]          io_out,
    output logic                io_oe,
    output logic                cle,
    output logic                ale,
    output logic                we_n,
    output logic                re_n,
    output logic                done,
    output logic [7:0]          rd_byte,
    output logic                ecc_upd,
    output logic [7:0]          ecc_byte
);
    import nbc_pkg::*;

    typedef struct packed {
        phase_e     ph;
        flash_op_e  op;
        logic [7:0] wbyte;
        logic [7:0] rbyte;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic active, last;

    assign active = (s_q.ph != PH_IDLE);
    assign last   = (s_q.ph == PH_STROBE) && (s_q.cnt == '0);

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE: if (start) begin
                s_d.ph    = PH_SETUP;
                s_d.op    = start_op;
                s_d.wbyte = start_byte;
            end
            PH_SETUP: begin
                s_d.ph  = PH_STROBE;
                s_d.cnt = CNT_W'(STROBE_CLKS - 1);
            end
            PH_STROBE: begin
                if (s_q.cnt == '0) begin
                    s_d.ph = PH_HOLD;
                    if (s_q.op == OP_DRD) s_d.rbyte = io_in;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_HOLD: s_d.ph = PH_IDLE;
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE, op: OP_CMD, default: '0};
        else        s_q <= s_d;
    end

    assign cle      = active && (s_q.op == OP_CMD);
    assign ale      = active && (s_q.op == OP_ADDR);
    assign io_oe    = active && (s_q.op != OP_DRD);
    assign io_out   = io_oe ? s_q.wbyte : 8'h00;
    assign we_n     = !((s_q.ph == PH_STROBE) && (s_q.op != OP_DRD));
    assign re_n     = !((s_q.ph == PH_STROBE) && (s_q.op == OP_DRD));
    assign done     = (s_q.ph == PH_HOLD);
    assign rd_byte  = s_q.rbyte;
    assign ecc_upd  = last && ((s_q.op == OP_DWR) || (s_q.op == OP_DRD));
    assign ecc_byte = (s_q.op == OP_DRD) ? io_in : s_q.wbyte;

endmodule

// File: rtl/nand_bus_ctrl.sv
module nand_bus_ctrl #(
    parameter int STROBE_CLKS = 2,
    parameter int BLOCK_BYTES = 256,
    localparam int IDX_W = $clog2(BLOCK_BYTES),
    localparam int ECC_W = 2 * (IDX_W + 1) + 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_req,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_ready,
    output logic        bus_err,
    output logic [7:0]  nf_io_out,
    output logic        nf_io_oe,
    input  logic [7:0]  nf_io_in,
    output logic        nf_cle,
    output logic        nf_ale,
    output logic        nf_ce_lvl,
    output logic        nf_we_n,
    output logic        nf_re_n,
    output logic        nf_wp_n,
    input  logic        wp_n_in,
    input  logic        nf_rb
);
    import nbc_pkg::*;

    typedef struct packed {
        bus_st_e     st;
        logic [15:0] cfg;
        logic [7:0]  cmd;
        logic [7:0]  adr;
        logic [31:0] rdata;
        logic        err;
    } ctl_t;

    ctl_t c_d, c_q;

    logic             seq_start, seq_done, ecc_upd, ecc_clr, en;
    flash_op_e        seq_op;
    logic [7:0]       seq_rd, ecc_byte;
    logic [ECC_W-1:0] ecc_word;
    logic [31:0]      ecc32;
    logic             wdata_unused;

    assign wdata_unused = ^bus_wdata[31:16];
    assign en    = c_q.cfg[CFG_EN_BIT];
    assign ecc32 = {{(32-ECC_W){1'b0}}, ecc_word};

    always_comb begin
        c_d       = c_q;
        seq_start = 1'b0;
        seq_op    = OP_CMD;
        ecc_clr   = 1'b0;
        unique case (c_q.st)
            BUS_IDLE: if (bus_req) begin
                c_d.st    = BUS_RESP;
                c_d.err   = 1'b0;
                c_d.rdata = '0;
                if (bus_wr) begin
                    unique case (bus_addr)
                        OFF_CFG: begin
                            c_d.cfg = bus_wdata[15:0] & CFG_KEEP;
                            ecc_clr = bus_wdata[CFG_CLR_BIT];
                        end
                        OFF_CMD: begin
                            c_d.cmd = bus_wdata[7:0];
                            if (en) begin seq_start = 1'b1; seq_op = OP_CMD; c_d.st = BUS_WAIT; end
                        end
                        OFF_ADR: begin
                            c_d.adr = bus_wdata[7:0];
                            if (en) begin seq_start = 1'b1; seq_op = OP_ADDR; c_d.st = BUS_WAIT; end
                        end
                        OFF_DAT: if (en) begin
                            seq_start = 1'b1; seq_op = OP_DWR; c_d.st = BUS_WAIT;
                        end
                        default: c_d.err = 1'b1;
                    endcase
                end else begin
                    unique case (bus_addr)
                        OFF_CFG:  c_d.rdata = {16'h0, c_q.cfg};
                        OFF_CMD:  c_d.rdata = {24'h0, c_q.cmd};
                        OFF_ADR:  c_d.rdata = {24'h0, c_q.adr};
                        OFF_DAT:  if (en) begin
                            seq_start = 1'b1; seq_op = OP_DRD; c_d.st = BUS_WAIT;
                        end
                        OFF_STS:  c_d.rdata = {31'h0, nf_rb};
                        OFF_ECC0: c_d.rdata = {24'h0, ecc32[7:0]};
                        OFF_ECC1: c_d.rdata = {24'h0, ecc32[15:8]};
                        OFF_ECC2: c_d.rdata = {24'h0, ecc32[23:16]};
                        default:  c_d.err = 1'b1;
                    endcase
                end
            end
            BUS_WAIT: if (seq_done) begin
                c_d.st    = BUS_RESP;
                c_d.rdata = {24'h0, seq_rd};
            end
            BUS_RESP: c_d.st = BUS_IDLE;
            default:  c_d.st = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: BUS_IDLE, default: '0};
        else        c_q <= c_d;
    end

    nbc_pin_seq #(.STROBE_CLKS(STROBE_CLKS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (seq_start),
        .start_op   (seq_op),
        .start_byte (bus_wdata[7:0]),
        .io_in      (nf_io_in),
        .io_out     (nf_io_out),
        .io_oe      (nf_io_oe),
        .cle        (nf_cle),
        .ale        (nf_ale),
        .we_n       (nf_we_n),
        .re_n       (nf_re_n),
        .done       (seq_done),
        .rd_byte    (seq_rd),
        .ecc_upd    (ecc_upd),
        .ecc_byte   (ecc_byte)
    );

    nbc_ecc_acc #(.BLOCK_BYTES(BLOCK_BYTES)) u_ecc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ecc_clr),
        .upd      (ecc_upd),
        .byte_in  (ecc_byte),
        .ecc_word (ecc_word)
    );

    assign bus_ready = (c_q.st == BUS_RESP);
    assign bus_err   = bus_ready && c_q.err;
    assign bus_rdata = c_q.rdata;
    assign nf_ce_lvl = c_q.cfg[CFG_CE_BIT];
    assign nf_wp_n   = wp_n_in;

endmodule

// File: rtl/nbc_checker.sv
module nbc_checker #(
    parameter int STROBE_CLKS = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ready,
    input logic       err,
    input logic       cle,
    input logic       ale,
    input logic       we_n,
    input logic       re_n,
    input logic       io_oe,
    input logic [7:0] io_out
);
    int unsigned lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              lo_cnt <= 0;
        else if (!we_n || !re_n) lo_cnt <= lo_cnt + 1;
        else                     lo_cnt <= 0;
    end

    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale)); // R6
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n)); // R8
    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (we_n && re_n && lo_cnt != 0) |-> (lo_cnt == STROBE_CLKS)); // R13
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready); // R13
    AST_ERR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ready); // R1
    AST_BUS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cle || ale || !we_n) |-> io_oe); // R7
    AST_BYTE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> $stable(io_out)); // R8

endmodule

bind nand_bus_ctrl nbc_checker #(.STROBE_CLKS(STROBE_CLKS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ready  (bus_ready),
    .err    (bus_err),
    .cle    (nf_cle),
    .ale    (nf_ale),
    .we_n   (nf_we_n),
    .re_n   (nf_re_n),
    .io_oe  (nf_io_oe),
    .io_out (nf_io_out)
);

// File: tb/nand_bus_ctrl_test.sv
module nand_bus_ctrl_test;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready, bus_err;
    logic [7:0]  nf_io_out, nf_io_in = 8'h00;
    logic        nf_io_oe, nf_cle, nf_ale, nf_ce_lvl, nf_we_n, nf_re_n, nf_wp_n;
    logic        wp_n_in = 1'b1, nf_rb = 1'b0;

    int tests = 0, fails = 0, cyc = 0;

    always #4 clk = ~clk;

    nand_bus_ctrl uut (.*);

    // pin monitor: strobe count, width and the byte/latch levels seen
    int        lo = 0, nstrobe = 0, last_w = 0;
    logic [7:0] m_io, last_io;
    logic      m_cle, m_ale, last_cle, last_ale;
    always @(negedge clk) begin
        if (!nf_we_n || !nf_re_n) begin
            lo++; m_io = nf_io_out; m_cle = nf_cle; m_ale = nf_ale;
        end else if (lo > 0) begin
            last_w = lo; nstrobe++; lo = 0;
            last_io = m_io; last_cle = m_cle; last_ale = m_ale;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++; tests++;
            $display("FAIL watchdog: run hung actual=%0d expected<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [4:0] a, input logic [31:0] d,
                       output logic [31:0] r, output logic e);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
        do @(negedge clk); while (!bus_ready);
        r = bus_rdata; e = bus_err; bus_req = 1'b0;
    endtask

    // ECC model built from the accumulation and packing rules
    bit [8:0] m_lpe, m_lpo;
    bit [5:0] m_cp;
    int       m_idx;
    task automatic m_clear();
        m_lpe = '0; m_lpo = '0; m_cp = '0; m_idx = 0;
    endtask
    task automatic m_push(input logic [7:0] b);
        bit p = ^b;
        for (int k = 0; k < 8; k++)
            if ((m_idx >> k) & 1) m_lpo[k] ^= p; else m_lpe[k] ^= p;
        m_lpe[8] ^= p;
        m_cp[0] ^= b[0]^b[2]^b[4]^b[6];
        m_cp[1] ^= b[1]^b[3]^b[5]^b[7];
        m_cp[2] ^= b[0]^b[1]^b[4]^b[5];
        m_cp[3] ^= b[2]^b[3]^b[6]^b[7];
        m_cp[4] ^= b[0]^b[1]^b[2]^b[3];
        m_cp[5] ^= b[4]^b[5]^b[6]^b[7];
        m_idx = (m_idx + 1) % 256;
    endtask
    function automatic logic [23:0] m_word();
        logic [23:0] w;
        for (int k = 0; k < 9; k++) begin
            w[2*k] = ~m_lpo[k]; w[2*k+1] = ~m_lpe[k];
        end
        w[23:18] = ~m_cp;
        return w;
    endfunction

    task automatic chk_ecc(input string tag, input logic [23:0] exp);
        logic [31:0] r; logic e;
        acc(1'b0, 5'h14, 0, r, e); chk({tag, " ecc[7:0] R10"},   r, {24'h0, exp[7:0]});
        acc(1'b0, 5'h15, 0, r, e); chk({tag, " ecc[15:8] R10"},  r, {24'h0, exp[15:8]});
        acc(1'b0, 5'h16, 0, r, e); chk({tag, " ecc[23:16] R10"}, r, {24'h0, exp[23:16]});
    endtask

    initial begin
        logic [31:0] r; logic e;
        int bad, n0;
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R13 ready idle after reset", {31'h0, bus_ready}, 0);
        chk("R6 pins idle after reset", {nf_cle, nf_ale, nf_we_n, nf_re_n, nf_ce_lvl}, 32'b00110);
        acc(1'b0, 5'h00, 0, r, e); chk("R2 config reset value", r, 0);
        m_clear(); chk_ecc("R9 reset", 24'hFFFFFF);

        // config masking, one-shot clear bit
        acc(1'b1, 5'h00, 32'hFFFF_FFFF, r, e);
        acc(1'b0, 5'h00, 0, r, e); chk("R2 config mask", r, 32'h0000_8FFF);
        chk("R5 ce level high", {31'h0, nf_ce_lvl}, 1);
        acc(1'b1, 5'h00, 32'h0000_1000, r, e);
        acc(1'b0, 5'h00, 0, r, e); chk("R2 bit12 not kept", r, 0);
        chk("R5 ce level low", {31'h0, nf_ce_lvl}, 0);
        wp_n_in = 1'b0; #1; chk("R5 wp low passes", {31'h0, nf_wp_n}, 0);
        wp_n_in = 1'b1; #1; chk("R5 wp high passes", {31'h0, nf_wp_n}, 1);

        // status
        nf_rb = 1'b1; acc(1'b0, 5'h10, 0, r, e); chk("R11 status ready", r, 1);
        nf_rb = 1'b0; acc(1'b0, 5'h10, 0, r, e); chk("R11 status busy", r, 0);

        // command and address cycles
        acc(1'b1, 5'h00, 32'h0000_8800, r, e);
        n0 = nstrobe;
        acc(1'b1, 5'h04, 32'h1234_5670, r, e);
        chk("R6 one strobe", nstrobe - n0, 1);
        chk("R6 cmd byte/latches", {last_io, 6'h0, last_cle, last_ale}, {8'h70, 6'h0, 2'b10});
        chk("R13 cmd strobe width", last_w, 2);
        chk("R6 cle dropped", {31'h0, nf_cle}, 0);
        acc(1'b0, 5'h04, 0, r, e); chk("R6 cmd stored", r, 32'h70);
        acc(1'b1, 5'h08, 32'hFFFF_FFAB, r, e);
        chk("R7 addr byte/latches", {last_io, 6'h0, last_cle, last_ale}, {8'hAB, 6'h0, 2'b01});
        chk("R13 addr strobe width", last_w, 2);

        // single byte pins down the bit positions
        acc(1'b1, 5'h00, 32'h0000_9800, r, e); m_clear();
        acc(1'b1, 5'h0C, 32'h0000_0001, r, e); m_push(8'h01);
        chk("R8 data byte/latches", {last_io, 6'h0, last_cle, last_ale}, {8'h01, 8'h00});
        chk_ecc("R9 single byte", 24'hA95555);
        chk("R12 model agrees single", {8'h0, m_word()}, 32'h00A95555);

        // full block of all byte values, then past the wrap
        acc(1'b1, 5'h00, 32'h0000_9800, r, e); m_clear();
        bad = 0;
        for (int i = 0; i < 256; i++) begin
            b = 8'((i * 167 + 3) % 256);
            acc(1'b1, 5'h0C, {24'hABCDEF, b}, r, e); m_push(b);
            if (last_io !== b || last_cle || last_ale) bad++;
        end
        chk("R8 write bytes reach flash", bad, 0);
        chk_ecc("R12 full block", m_word());
        for (int i = 0; i < 44; i++) begin
            b = 8'(i * 29 + 200);
            acc(1'b1, 5'h0C, {24'h0, b}, r, e); m_push(b);
        end
        chk_ecc("R12 after wrap", m_word());

        // ECC clear while data present
        acc(1'b1, 5'h00, 32'h0000_9800, r, e); m_clear();
        chk_ecc("R4 clear", 24'hFFFFFF);

        // data reads
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            b = 8'(i * 73 + 5);
            nf_io_in = b;
            acc(1'b0, 5'h0C, 0, r, e); m_push(b);
            if (r !== {24'h0, b}) bad++;
        end
        chk("R8 read bytes returned", bad, 0);
        chk("R13 read strobe width", last_w, 2);
        chk_ecc("R8 read ecc", m_word());

        // erased page
        acc(1'b1, 5'h00, 32'h0000_9800, r, e); m_clear();
        for (int i = 0; i < 256; i++) acc(1'b1, 5'h0C, 32'hFF, r, e);
        chk_ecc("R9 erased page", 24'hFFFFFF);

        // disabled controller
        acc(1'b1, 5'h00, 32'h0000_0800, r, e);
        n0 = nstrobe;
        acc(1'b1, 5'h04, 32'h0000_0033, r, e);
        acc(1'b1, 5'h08, 32'h0000_0044, r, e);
        acc(1'b1, 5'h0C, 32'h0000_0012, r, e);
        nf_io_in = 8'h5C;
        acc(1'b0, 5'h0C, 0, r, e); chk("R3 disabled read zero", r, 0);
        chk("R3 no strobes when disabled", nstrobe - n0, 0);
        acc(1'b0, 5'h08, 0, r, e); chk("R3 addr stored when disabled", r, 32'h44);
        chk_ecc("R3 ecc untouched", 24'hFFFFFF);

        // invalid offsets
        acc(1'b0, 5'h18, 0, r, e); chk("R1 bad read err", {e, r[30:0]}, 32'h8000_0000);
        acc(1'b1, 5'h10, 32'hFFFF_FFFF, r, e); chk("R1 status write err", {31'h0, e}, 1);
        acc(1'b1, 5'h14, 32'h0000_1000, r, e); chk("R1 ecc write err", {31'h0, e}, 1);
        acc(1'b1, 5'h01, 32'h0000_9FFF, r, e); chk("R1 unaligned write err", {31'h0, e}, 1);
        acc(1'b0, 5'h00, 0, r, e); chk("R1 config unchanged", r, 32'h0800);
        chk("R1 good access no err", {31'h0, e}, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule